// File: doc/BRIEF.md
# Interleaved Memory Block Fetcher

This block refills one cache line from a main memory split into four banks, with words interleaved across the banks. A requester presents a block address together with a start strobe. The block then spends one cycle sending the block's row address to all four banks at once. The four banks run their fixed-latency access at the same time. When the access is done, the four captured words go out one per cycle on a single narrow data bus, with a valid strobe and a flag on the final word.

The banks are plain arrays inside the block and have a fixed access time. A simple word write port fills them. Because the banks work in parallel and only the transfer is serial, a four-word refill takes 1 + 6 + 4 = 11 cycles. Four separate word reads one after another would take 32 cycles. While a refill is in progress the block reports busy and ignores new start strobes and writes.

Top module: `interleaved_refill`

## Requirements
- R1: A synchronous active-high reset, including one that arrives in the middle of a refill, leaves `busy`, `rd_valid` and `rd_last` low in the cycle after the reset edge.
- R2: A start strobe is taken only while `busy` is low. A strobe seen while `busy` is high starts no extra burst.
- R3: Count the clock edge that accepts a request as edge 0. `busy` is high in cycles 1 through 11 after that edge and low in cycle 12.
- R4: `rd_valid` is high in cycles 8, 9, 10 and 11 after the accepting edge and low in every other cycle, giving exactly four consecutive valid cycles per request.
- R5: `rd_last` is high only together with the fourth valid word, in cycle 11.
- R6: The words come out in bank order 0, 1, 2, 3. With block base B, the k-th valid word (k = 0..3) is memory word B + k.
- R7: The two low bits of `req_addr` are ignored. The block base is `req_addr` with bits [1:0] cleared.
- R8: A write stores `wr_data` as memory word `wr_addr`, in bank `wr_addr[1:0]` at row `wr_addr[AW-1:2]`. A write presented while `busy` is high changes nothing.
- R9: `rd_data` is all zero in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start a block refill |
| req_addr | input | AW | Word address of the block; bits [1:0] ignored |
| busy | output | 1 | Refill in progress |
| wr_en | input | 1 | Write one memory word (only while idle) |
| wr_addr | input | AW | Word address to write |
| wr_data | input | DW | Word to write |
| rd_valid | output | 1 | A block word is on `rd_data` |
| rd_last | output | 1 | Fourth and final word of the block |
| rd_data | output | DW | Returned word, zero when not valid |

## Verification
The assertions check the refill's timing shape on every cycle:
- the fixed gap from acceptance to the first valid word;
- the run of exactly four valid cycles, ending on `rd_last`;
- `busy` holding steady until the last word and dropping right after it;
- zero data outside the valid window;
- the reset clearing the strobes.

Only the bench's scenarios can show data correctness:
- that each word really comes from the right bank and row in bank order;
- that the low address bits make no difference;
- that writes and start strobes arriving during a refill leave the memory and the output untouched.

// File: rtl/interleaved_refill.sv
module interleaved_refill #(
  parameter int DW      = 32,
  parameter int AW      = 6,
  parameter int NB      = 4,
  parameter int ACC_CYC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [DW-1:0] rd_data
);

  localparam int BB   = $clog2(NB);
  localparam int RW   = AW - BB;
  localparam int ROWS = 1 << RW;
  localparam int CW   = $clog2(ACC_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_ACC, S_XFER} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [BB-1:0]   idx;
  logic [RW-1:0]   row_q;
  logic [DW-1:0]   line_w [NB];

  wire accept = req_valid && (state == S_IDLE);
  wire cap    = (state == S_ACC) && (cnt == CW'(ACC_CYC - 1));
  wire wr_ok  = wr_en && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      row_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          row_q <= req_addr[AW-1:BB];
          state <= S_SEND;
        end
        S_SEND: begin
          cnt   <= '0;
          state <= S_ACC;
        end
        S_ACC: begin
          cnt <= cnt + 1'b1;
          if (cap) begin
            idx   <= '0;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          idx <= idx + 1'b1;
          if (idx == BB'(NB - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [ROWS];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_ok && wr_addr[BB-1:0] == BB'(b)) mem[wr_addr[AW-1:BB]] <= wr_data;
      if (cap) q <= mem[row_q];
    end
    assign line_w[b] = q;
  end

  assign busy     = (state != S_IDLE);
  assign rd_valid = (state == S_XFER);
  assign rd_last  = rd_valid && (idx == BB'(NB - 1));
  assign rd_data  = rd_valid ? line_w[idx] : '0;

endmodule

// File: rtl/interleaved_refill_chk.sv
module interleaved_refill_chk #(
  parameter int DW      = 32,
  parameter int ACC_CYC = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          rd_valid,
  input logic          rd_last,
  input logic [DW-1:0] rd_data
);

  logic [7:0] lat;
  logic [2:0] vrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat  <= '0;
      vrun <= '0;
    end else begin
      lat  <= busy ? lat + 1'b1 : '0;
      vrun <= rd_valid ? vrun + 1'b1 : '0;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !rd_valid && !rd_last));

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_last) |=> busy);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  a_r3_drop_after_last: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> !busy);

  a_r4_first_word_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> (lat == 8'(ACC_CYC + 1)));

  a_r4_run_length: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |=> rd_valid);

  a_r5_last_fourth: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> (rd_valid && vrun == 3'd3));

  a_r9_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

endmodule

bind interleaved_refill interleaved_refill_chk #(.DW(DW), .ACC_CYC(ACC_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
);

// File: tb/test_interleaved_refill.sv
module test_interleaved_refill;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam int NREQ = 6;
  localparam logic [AW-1:0] REQ_TAB [NREQ] = '{6'd0, 6'd4, 6'd21, 6'd63, 6'd34, 6'd14};

  logic clk = 0, rst = 1, req_valid = 0, wr_en = 0;
  logic [AW-1:0] req_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic busy, rd_valid, rd_last;
  logic [DW-1:0] shadow [NW];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  interleaved_refill i_interleaved_refill (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data));

  function automatic logic [DW-1:0] pat(int w, int salt);
    return {8'hC3 ^ 8'(salt), 8'(w), 16'(w * w + 7 + salt)};
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(int w, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(w); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_block(logic [AW-1:0] a);
    int base = int'({a[AW-1:2], 2'b00});
    @(negedge clk);
    req_valid = 1; req_addr = a;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 0;
      chk(busy == (k <= 11), "R3 busy", DW'(busy), DW'(k <= 11));
      chk(rd_valid == (k >= 8 && k <= 11), "R4 valid", DW'(rd_valid), DW'(k >= 8 && k <= 11));
      chk(rd_last == (k == 11), "R5 last", DW'(rd_last), DW'(k == 11));
      if (k >= 8 && k <= 11)
        chk(rd_data == shadow[base + k - 8], "R6 R7 data", rd_data, shadow[base + k - 8]);
      else
        chk(rd_data == '0, "R9 idle data", rd_data, '0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !rd_last, "R1 reset state", {busy, rd_valid, rd_last}, '0);
    rst = 0;
    for (int w = 0; w < NW; w++) begin
      shadow[w] = pat(w, 0);
      write_word(w, shadow[w]);
    end
    for (int i = 0; i < NREQ; i++) run_block(REQ_TAB[i]);

    // R7: same block through each low-bit value
    for (int lo = 0; lo < 4; lo++) run_block(AW'(40 + lo));

    // R2: start strobe held during busy starts nothing extra
    @(negedge clk);
    req_valid = 1; req_addr = 6'd8;
    repeat (11) @(negedge clk);
    chk(rd_last, "R2 first burst last", DW'(rd_last), 1);
    req_valid = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!busy && !rd_valid, "R2 no extra burst", {busy, rd_valid}, '0);
    end

    // R8: write during busy is ignored, write while idle lands
    @(negedge clk);
    req_valid = 1; req_addr = 6'd16;
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_addr = 6'd5; wr_data = 32'hDEADBEEF;
    @(negedge clk);
    wr_en = 0;
    repeat (12) @(negedge clk);
    run_block(6'd4);
    shadow[6] = pat(6, 9);
    write_word(6, shadow[6]);
    run_block(6'd7);
    chk(shadow[6] != pat(6, 0), "R8 bank 2 row 1 rewritten", shadow[6], pat(6, 9));

    // R1: reset in the middle of the transfer
    @(negedge clk);
    req_valid = 1; req_addr = 6'd24;
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    chk(rd_valid, "R1 mid-transfer precondition", DW'(rd_valid), 1);
    rst = 1;
    @(negedge clk);
    chk(!busy && !rd_valid && !rd_last, "R1 mid-burst reset", {busy, rd_valid, rd_last}, '0);
    rst = 0;
    run_block(6'd24);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule